// File: doc/BRIEF.md
# Single-Wire Half-Duplex Line Controller

This block sits between a serial transmitter, a serial receiver and the pad logic of one shared bidirectional wire. With half-duplex selected, the transmitter's bit stream reaches the wire through an open-drain style control. A 0 bit pulls the wire low. A 1 bit releases it to the external pull-up. The receiver's serial input is then taken from the wire itself, and the dedicated receive pin is disregarded. When half-duplex is not selected, or cannot be applied, the block falls back to full-duplex routing. In that case the transmit bit leaves on a push-pull output and the receiver listens to its own pin.

Half-duplex is applied only while the synchronous clock output is disabled. If both are requested, a mode-error flag is raised and the block stays in full-duplex routing. In half-duplex the receiver is never enabled while a frame is going out. A receive-enable request is granted one clock after the transmit-complete flag reads 1. A request held during a transmission therefore waits and is granted once that transmission finishes. Starting a transmission clears transmit-complete and withdraws any granted receive enable. Collisions on the wire are not arbitrated here. Software reads the status and decides.

Top module: `hdx_wire_ctl`

## Requirements
- R1: After reset, line_drive_low_o=0, tx_pp_o=1, tx_cmplt_o=1, rx_en_o=0, hd_active_o=0 and mode_err_o=0.
- R2: hd_en_i=1 with sclk_en_i=0 sets hd_active_o=1 and mode_err_o=0 at the next clock edge.
- R3: hd_en_i=1 with sclk_en_i=1 sets mode_err_o=1 and hd_active_o=0 at the next clock edge, and the block then routes as in full-duplex.
- R4: In half-duplex, line_drive_low_o is registered as tx_active_i AND NOT tx_bit_i (1 = pull wire low), and tx_pp_o stays 1.
- R5: Outside half-duplex, line_drive_low_o stays 0, and tx_pp_o is registered as tx_bit_i while tx_active_i=1, else 1.
- R6: In half-duplex, rx_data_o equals line_i delayed by SYNC_STAGES clocks (default 2), and rx_pin_i has no effect on it.
- R7: Outside half-duplex, rx_data_o equals rx_pin_i delayed by SYNC_STAGES clocks, and line_i has no effect on it.
- R8: tx_cmplt_o clears at the edge where tx_start_i=1 and sets at the edge where tx_done_i=1 with tx_start_i=0. Start wins when both are 1.
- R9: In half-duplex, rx_en_o rises at the edge where rx_en_req_i=1 and tx_cmplt_o was already 1. A request held while tx_cmplt_o=0 is granted one edge after tx_cmplt_o returns to 1.
- R10: In half-duplex, a tx_start_i pulse drops rx_en_o at that same edge.
- R11: Outside half-duplex, rx_en_o follows rx_en_req_i one clock later, whatever the state of tx_cmplt_o.
- R12: While hd_active_o=1, rx_en_o=1 never occurs with tx_cmplt_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_en_i | input | 1 | Half-duplex mode request |
| sclk_en_i | input | 1 | Synchronous clock output enabled |
| tx_start_i | input | 1 | Pulse: transmitter begins a frame |
| tx_active_i | input | 1 | Transmitter is shifting a frame |
| tx_bit_i | input | 1 | Current transmit bit |
| tx_done_i | input | 1 | Pulse: transmitter finished a frame |
| rx_en_req_i | input | 1 | Receive enable request (level) |
| rx_pin_i | input | 1 | Dedicated receive pin |
| line_i | input | 1 | Sampled level of the shared wire |
| line_drive_low_o | output | 1 | Pull shared wire low |
| tx_pp_o | output | 1 | Push-pull transmit output (full-duplex) |
| rx_data_o | output | 1 | Synchronised serial data to receiver |
| tx_cmplt_o | output | 1 | Transmit-complete status |
| rx_en_o | output | 1 | Granted receive enable |
| hd_active_o | output | 1 | Half-duplex applied |
| mode_err_o | output | 1 | Half-duplex requested with sync clock on |

## Verification
The bench holds a receive request across a whole transmission. A design that granted it early would enable the receiver during the frame. A design that dropped the request would never enable the receiver at all. It also raises half-duplex together with the synchronous clock, where a faulty design would pull the wire low or take receive data from the wire. It swaps the wire and the receive pin so that the unused source changes. This catches a mux that ignores the mode. Finally it pulses start and done together, and expects start to win.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_HALF  = 2'd1,
    MODE_FAULT = 2'd2
  } hdx_mode_e;
endpackage

// File: rtl/hdx_mode_ctl.sv
module hdx_mode_ctl
  import hdx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hd_en_i,
  input  logic      sclk_en_i,
  output hdx_mode_e mode_o,
  output logic      hd_active_o,
  output logic      mode_err_o
);
  hdx_mode_e mode_d;

  always_comb begin
    if (!hd_en_i)       mode_d = MODE_FULL;
    else if (sclk_en_i) mode_d = MODE_FAULT;
    else                mode_d = MODE_HALF;
  end

  assign mode_o = mode_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_active_o <= 1'b0;
      mode_err_o  <= 1'b0;
    end else begin
      hd_active_o <= (mode_d == MODE_HALF);
      mode_err_o  <= (mode_d == MODE_FAULT);
    end
  end

  p_err_needs_sclk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_en_i && sclk_en_i |=> mode_err_o && !hd_active_o);
  p_half_applied_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_en_i && !sclk_en_i |=> hd_active_o && !mode_err_o);
endmodule

// File: rtl/hdx_line_drv.sv
module hdx_line_drv #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  input  logic tx_active_i,
  input  logic tx_bit_i,
  input  logic rx_pin_i,
  input  logic line_i,
  output logic line_drive_low_o,
  output logic tx_pp_o,
  output logic rx_data_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic                   rx_src;
  logic [SYNC_STAGES-1:0] sync_q;

  // open-drain: only ever pull low, release for 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_drive_low_o <= 1'b0;
      tx_pp_o          <= 1'b1;
    end else begin
      line_drive_low_o <= half_i & tx_active_i & ~tx_bit_i;
      tx_pp_o          <= (half_i | ~tx_active_i) ? 1'b1 : tx_bit_i;
    end
  end

  assign rx_src = half_i ? line_i : rx_pin_i;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= rx_src;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign rx_data_o = sync_q[LAST];

  p_no_pull_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_i |=> !line_drive_low_o);
  p_release_on_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i && tx_bit_i |=> !line_drive_low_o && tx_pp_o);
endmodule

// File: rtl/hdx_rx_gate.sv
module hdx_rx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  input  logic tx_start_i,
  input  logic tx_done_i,
  input  logic rx_en_req_i,
  output logic tx_cmplt_o,
  output logic rx_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cmplt_o <= 1'b1;
      rx_en_o    <= 1'b0;
    end else begin
      if (tx_start_i)     tx_cmplt_o <= 1'b0;
      else if (tx_done_i) tx_cmplt_o <= 1'b1;
      // held request stays pending until complete was seen
      rx_en_o <= half_i ? (rx_en_req_i & tx_cmplt_o & ~tx_start_i) : rx_en_req_i;
    end
  end

  p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> !tx_cmplt_o);
  p_done_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !tx_start_i |=> tx_cmplt_o);
  p_start_drops_rx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i && tx_start_i |=> !rx_en_o);
  p_full_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_i |=> rx_en_o == $past(rx_en_req_i));
endmodule

// File: rtl/hdx_wire_ctl.sv
module hdx_wire_ctl
  import hdx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_en_i,
  input  logic sclk_en_i,
  input  logic tx_start_i,
  input  logic tx_active_i,
  input  logic tx_bit_i,
  input  logic tx_done_i,
  input  logic rx_en_req_i,
  input  logic rx_pin_i,
  input  logic line_i,
  output logic line_drive_low_o,
  output logic tx_pp_o,
  output logic rx_data_o,
  output logic tx_cmplt_o,
  output logic rx_en_o,
  output logic hd_active_o,
  output logic mode_err_o
);
  hdx_mode_e mode;
  logic      half;

  hdx_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hd_en_i     (hd_en_i),
    .sclk_en_i   (sclk_en_i),
    .mode_o      (mode),
    .hd_active_o (hd_active_o),
    .mode_err_o  (mode_err_o)
  );

  assign half = (mode == MODE_HALF);

  hdx_line_drv #(.SYNC_STAGES(SYNC_STAGES)) u_drv (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .half_i           (half),
    .tx_active_i      (tx_active_i),
    .tx_bit_i         (tx_bit_i),
    .rx_pin_i         (rx_pin_i),
    .line_i           (line_i),
    .line_drive_low_o (line_drive_low_o),
    .tx_pp_o          (tx_pp_o),
    .rx_data_o        (rx_data_o)
  );

  hdx_rx_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_i      (half),
    .tx_start_i  (tx_start_i),
    .tx_done_i   (tx_done_i),
    .rx_en_req_i (rx_en_req_i),
    .tx_cmplt_o  (tx_cmplt_o),
    .rx_en_o     (rx_en_o)
  );

  p_no_rx_during_tx_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_active_o && rx_en_o |-> tx_cmplt_o);
  p_fault_no_pull_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !line_drive_low_o);
  p_half_pp_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_active_o |-> tx_pp_o);
endmodule

// File: tb/hdx_wire_ctl_tb.sv
module hdx_wire_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_en = 0, sclk_en = 0, tx_start = 0, tx_active = 0, tx_bit = 0, tx_done = 0;
  logic rx_req = 0, rx_pin = 1, line = 1;
  logic drv_low, tx_pp, rx_data, cmplt, rx_en, hd_act, merr;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  hdx_wire_ctl #(.SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hd_en_i(hd_en), .sclk_en_i(sclk_en),
    .tx_start_i(tx_start), .tx_active_i(tx_active), .tx_bit_i(tx_bit),
    .tx_done_i(tx_done), .rx_en_req_i(rx_req), .rx_pin_i(rx_pin), .line_i(line),
    .line_drive_low_o(drv_low), .tx_pp_o(tx_pp), .rx_data_o(rx_data),
    .tx_cmplt_o(cmplt), .rx_en_o(rx_en), .hd_active_o(hd_act), .mode_err_o(merr)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(logic act, logic exp, string req, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    chk(drv_low, 0, "R1", "drive_low"); chk(tx_pp, 1, "R1", "tx_pp");
    chk(cmplt, 1, "R1", "cmplt");       chk(rx_en, 0, "R1", "rx_en");
    chk(hd_act, 0, "R1", "hd_active");  chk(merr, 0, "R1", "mode_err");
  endtask

  task automatic t_mode_half;
    hd_en = 1; sclk_en = 0; tick();
    chk(hd_act, 1, "R2", "hd_active"); chk(merr, 0, "R2", "mode_err");
  endtask

  task automatic t_mode_fault;
    sclk_en = 1; tick();
    chk(merr, 1, "R3", "mode_err"); chk(hd_act, 0, "R3", "hd_active");
    tx_active = 1; tx_bit = 0; tick();
    chk(drv_low, 0, "R3", "no pull in fault"); chk(tx_pp, 0, "R3", "pp carries bit");
    tx_active = 0; sclk_en = 0; tick();
    chk(merr, 0, "R3", "err clears"); chk(hd_act, 1, "R2", "half back");
  endtask

  task automatic t_drive_half;
    tx_active = 1; tx_bit = 0; tick();
    chk(drv_low, 1, "R4", "pull for 0"); chk(tx_pp, 1, "R4", "pp idle");
    tx_bit = 1; tick();
    chk(drv_low, 0, "R4", "release for 1");
    tx_active = 0; tx_bit = 0; tick();
    chk(drv_low, 0, "R4", "idle release");
  endtask

  task automatic t_drive_full;
    hd_en = 0; tx_active = 1; tx_bit = 0; tick();
    chk(drv_low, 0, "R5", "no pull full"); chk(tx_pp, 0, "R5", "pp 0");
    tx_bit = 1; tick();
    chk(tx_pp, 1, "R5", "pp 1");
    tx_active = 0; tx_bit = 0; tick();
    chk(tx_pp, 1, "R5", "pp idle");
  endtask

  task automatic t_rx_path;
    hd_en = 1; line = 1; rx_pin = 1; tick(3);
    line = 0; rx_pin = 1; tick();
    chk(rx_data, 1, "R6", "latency stage 1");
    tick();
    chk(rx_data, 0, "R6", "wire sampled");
    line = 1; rx_pin = 0; tick(2);
    chk(rx_data, 1, "R6", "pin ignored");
    hd_en = 0; line = 1; rx_pin = 1; tick(3);
    line = 0; tick(2);
    chk(rx_data, 1, "R7", "wire ignored");
    rx_pin = 0; line = 1; tick(2);
    chk(rx_data, 0, "R7", "pin sampled");
    rx_pin = 1; tick(2);
  endtask

  task automatic t_cmplt;
    hd_en = 1; tick();
    tx_start = 1; tick(); tx_start = 0;
    chk(cmplt, 0, "R8", "start clears");
    tick();
    chk(cmplt, 0, "R8", "stays clear");
    tx_done = 1; tick(); tx_done = 0;
    chk(cmplt, 1, "R8", "done sets");
    tx_start = 1; tx_done = 1; tick(); tx_start = 0; tx_done = 0;
    chk(cmplt, 0, "R8", "start wins");
    tx_done = 1; tick(); tx_done = 0;
    chk(cmplt, 1, "R8", "done again");
  endtask

  task automatic t_rx_gate;
    rx_req = 1; tick();
    chk(rx_en, 1, "R9", "grant when complete");
    tx_start = 1; tick(); tx_start = 0;
    chk(rx_en, 0, "R10", "start withdraws");
    tick(3);
    chk(rx_en, 0, "R12", "held off during tx");
    tx_done = 1; tick(); tx_done = 0;
    chk(cmplt, 1, "R9", "complete set");
    chk(rx_en, 0, "R9", "not yet granted");
    tick();
    chk(rx_en, 1, "R9", "pending granted");
    rx_req = 0; tick();
    chk(rx_en, 0, "R9", "request dropped");
  endtask

  task automatic t_rx_full;
    hd_en = 0; tick();
    tx_start = 1; tick(); tx_start = 0;
    rx_req = 1; tick();
    chk(cmplt, 0, "R11", "tx busy");
    chk(rx_en, 1, "R11", "ungated");
    tx_done = 1; rx_req = 0; tick(); tx_done = 0;
    chk(rx_en, 0, "R11", "follows");
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    #3 rst_n = 1'b1;
    tick();
    t_reset();
    t_mode_half();
    t_mode_fault();
    t_drive_half();
    t_drive_full();
    t_rx_path();
    t_cmplt();
    t_rx_gate();
    t_rx_full();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule